// File: doc/BRIEF.md
# SPI Transfer Event Interrupt Collector

This block sits beside an SPI master and turns its single-cycle event pulses into a sticky event record. Nine conditions are captured: master done, slave done, receive request, receive overflow, receive underflow, transmit request, transmit overflow, transmit underflow and multiple-master conflict. Each event bit stays set until software writes a one to it. A separate mask register holds one bit per event, and a set mask bit keeps that event from raising the interrupt.

Two status signals are derived from the registers. The pending flag is combinational: it is high when any recorded event has its mask bit clear. Software reads it to reject interrupts that have no cause. The interrupt line is a registered copy of the pending flag. An error flag reports that an event of the transfer-terminating class has been recorded, whatever the mask holds. Both registers can be read back through a select input.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset, all mask bits read 1, all event bits read 0, and irq, pending and term_err are 0.
- R2: An evt_pulse bit set in cycle N sets the matching event bit from cycle N+1 on. The bit stays set until it is acknowledged. Bit order: 0 master done, 1 slave done, 2 rx request, 3 rx overflow, 4 rx underflow, 5 tx request, 6 tx overflow, 7 tx underflow, 8 multiple-master.
- R3: A write with wr_sel=1 clears every event bit whose wr_data bit is 1 and leaves the bits written with 0 unchanged.
- R4: If an event pulse arrives in the same cycle as an acknowledge of the same bit, the bit stays set.
- R5: A write with wr_sel=0 loads wr_data into the mask register from the next cycle on. An acknowledge write does not change the mask, and a mask write does not change the events.
- R6: pending is 1 exactly when some event bit is 1 while its mask bit is 0.
- R7: irq equals the value pending had one cycle earlier.
- R8: term_err is 1 exactly when any of event bits 1, 3, 4, 6 or 8 is set, regardless of the mask.
- R9: A masked event is still recorded in the event register.
- R10: rd_data shows the mask register when rd_sel=0 and the event register when rd_sel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 9 | One-cycle event pulses, one per event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mask, 1 event acknowledge |
| wr_data | input | 9 | Write data |
| rd_sel | input | 1 | Read select: 0 mask, 1 events |
| rd_data | output | 9 | Read-back data |
| pending | output | 1 | An unmasked event is recorded |
| irq | output | 1 | Registered interrupt request |
| term_err | output | 1 | A transfer-terminating event is recorded |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same cycle as a new pulse on the same bit. Random traffic rarely lines the two up, so a directed step sets a bit, then drives the pulse and its acknowledge together, and reads the event register right after. The random phase biases its pulses toward sparse bits and its writes toward acknowledges, so that bits are often set and cleared near each other while a random mask is in place.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int EVT_COUNT = 9;

    localparam int EV_MASTER_DONE = 0;
    localparam int EV_SLAVE_DONE  = 1;
    localparam int EV_RX_REQ      = 2;
    localparam int EV_RX_OVF      = 3;
    localparam int EV_RX_UNF      = 4;
    localparam int EV_TX_REQ      = 5;
    localparam int EV_TX_OVF      = 6;
    localparam int EV_TX_UNF      = 7;
    localparam int EV_MULTI_MSTR  = 8;

    localparam logic [EVT_COUNT-1:0] FATAL_SET =
        (EVT_COUNT'(1) << EV_SLAVE_DONE) | (EVT_COUNT'(1) << EV_RX_OVF) |
        (EVT_COUNT'(1) << EV_RX_UNF)     | (EVT_COUNT'(1) << EV_TX_OVF) |
        (EVT_COUNT'(1) << EV_MULTI_MSTR);

    typedef enum logic { SEL_MASK = 1'b0, SEL_EVENT = 1'b1 } reg_sel_e;
endpackage

// File: rtl/spi_irq_evt_reg.sv
module spi_irq_evt_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pulse_i,
    input  logic [W-1:0] ack_i,
    output logic [W-1:0] state_o
);
    typedef struct packed {
        logic [W-1:0] evt;
    } evt_st_t;

    evt_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        // set wins over clear
        nxt_d.evt = (cur_q.evt & ~ack_i) | pulse_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign state_o = cur_q.evt;

    AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_i) |=> ((state_o & $past(pulse_i)) == $past(pulse_i))); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_i) |=> ((state_o & $past(ack_i) & ~$past(pulse_i)) == '0)); // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i == '0) |=> ((($past(state_o)) & ~state_o) == '0)); // R2
endmodule

// File: rtl/spi_irq_gate.sv
module spi_irq_gate #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_wdata_i,
    output logic [W-1:0] mask_o,
    output logic         pend_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic         irq;
    } gate_st_t;

    gate_st_t cur_q, nxt_d;
    logic     pend_w;

    always_comb begin
        pend_w = |(evt_i & ~cur_q.mask);
        nxt_d  = cur_q;
        if (mask_we_i) nxt_d.mask = mask_wdata_i;
        nxt_d.irq = pend_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.mask <= '1;
            cur_q.irq  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mask_o = cur_q.mask;
    assign pend_o = pend_w;
    assign irq_o  = cur_q.irq;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(pend_o))); // R7
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_o == $past(mask_wdata_i))); // R5
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '1) |-> !pend_o); // R6
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int                  NUM_EVT = EVT_COUNT,
    parameter logic [NUM_EVT-1:0]  ERR_SEL = FATAL_SET
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [NUM_EVT-1:0] wr_data,
    input  logic               rd_sel,
    output logic [NUM_EVT-1:0] rd_data,
    output logic               pending,
    output logic               irq,
    output logic               term_err
);
    logic [NUM_EVT-1:0] ack_d;
    logic               mask_we_d;
    logic [NUM_EVT-1:0] evt_q;
    logic [NUM_EVT-1:0] mask_q;

    always_comb begin
        mask_we_d = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);
        ack_d     = (wr_en && (reg_sel_e'(wr_sel) == SEL_EVENT)) ? wr_data : '0;
    end

    spi_irq_evt_reg #(.W(NUM_EVT)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (evt_pulse),
        .ack_i   (ack_d),
        .state_o (evt_q)
    );

    spi_irq_gate #(.W(NUM_EVT)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_q),
        .mask_we_i    (mask_we_d),
        .mask_wdata_i (wr_data),
        .mask_o       (mask_q),
        .pend_o       (pending),
        .irq_o        (irq)
    );

    always_comb begin
        term_err = |(evt_q & ERR_SEL);
        rd_data  = (reg_sel_e'(rd_sel) == SEL_EVENT) ? evt_q : mask_q;
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_d |=> $stable(mask_q)); // R5
    AST_MASKED_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_pulse & mask_q)) |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse))); // R9
endmodule

// File: tb/spi_irq_unit_test.sv
module spi_irq_unit_test;
    localparam int N = 9;
    localparam logic [N-1:0] ERRS = 9'h15A;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] evt_pulse;
    logic         wr_en, wr_sel, rd_sel;
    logic [N-1:0] wr_data;
    logic [N-1:0] rd_data;
    logic         pending, irq, term_err;

    int total = 0;
    int bad   = 0;
    logic [N-1:0] em, mm;
    logic         im;

    always #2 clk = ~clk;

    spi_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .pending(pending), .irq(irq), .term_err(term_err)
    );

    function automatic logic [N-1:0] nxt_evt(logic [N-1:0] e, logic [N-1:0] p,
                                             logic we, logic s, logic [N-1:0] d);
        logic [N-1:0] a = (we && s) ? d : '0;
        return (e & ~a) | p;
    endfunction

    function automatic logic [N-1:0] nxt_mask(logic [N-1:0] m, logic we, logic s,
                                              logic [N-1:0] d);
        return (we && !s) ? d : m;
    endfunction

    task automatic chk(bit ok, string tag, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [N-1:0] exp_rd = rd_sel ? em : mm;
        chk(rd_data == exp_rd, {tag, " R10 read"}, rd_data, exp_rd);
        chk(pending == |(em & ~mm), {tag, " R6 pending"}, N'(pending), N'(|(em & ~mm)));
        chk(irq == im, {tag, " R7 irq"}, N'(irq), N'(im));
        chk(term_err == |(em & ERRS), {tag, " R8 term_err"}, N'(term_err), N'(|(em & ERRS)));
    endtask

    task automatic step(logic [N-1:0] p, logic we, logic s, logic [N-1:0] d,
                        logic rs, string tag);
        @(negedge clk);
        evt_pulse = p; wr_en = we; wr_sel = s; wr_data = d; rd_sel = rs;
        im = |(em & ~mm);
        em = nxt_evt(em, p, we, s, d);
        mm = nxt_mask(mm, we, s, d);
        @(posedge clk);
        @(negedge clk);
        evt_pulse = '0; wr_en = 1'b0;
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357));
        rst_n = 1'b0; evt_pulse = '0; wr_en = 1'b0; wr_sel = 1'b0;
        wr_data = '0; rd_sel = 1'b0;
        em = '0; mm = '1; im = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        chk(rd_data == 9'h1FF, "R1 mask after reset", rd_data, 9'h1FF);
        chk(!pending && !irq && !term_err, "R1 flags after reset",
            {6'd0, pending, irq, term_err}, '0);
        rd_sel = 1'b1;
        #1;
        chk(rd_data == '0, "R1 events after reset", rd_data, '0);
        rst_n = 1'b1;

        // R9 masked event recorded, R2 sticky
        step(9'h004, 0, 0, '0, 1, "R9 masked rx req");
        chk(rd_data == 9'h004, "R9 recorded", rd_data, 9'h004);
        step('0, 0, 0, '0, 1, "R2 hold");
        chk(rd_data == 9'h004, "R2 sticky", rd_data, 9'h004);
        chk(!term_err, "R8 non-error bit", N'(term_err), '0);
        // R5 unmask, R6/R7 timing
        step('0, 1, 0, 9'h0FB, 0, "R5 unmask bit2");
        chk(rd_data == 9'h0FB, "R5 mask loaded", rd_data, 9'h0FB);
        chk(pending && !irq, "R6 pend before irq", {7'd0, pending, irq}, 9'h002);
        step('0, 0, 0, '0, 1, "R7 irq lag");
        chk(irq, "R7 irq rises", N'(irq), 9'h001);
        // R8 error class
        step(9'h008, 0, 0, '0, 1, "R8 rx ovf");
        chk(term_err, "R8 error set", N'(term_err), 9'h001);
        // R3 partial ack
        step('0, 1, 1, 9'h008, 1, "R3 ack one");
        chk(rd_data == 9'h004, "R3 only acked cleared", rd_data, 9'h004);
        step('0, 1, 1, 9'h000, 0, "R5 ack leaves mask");
        chk(rd_data == 9'h0FB, "R5 mask unchanged", rd_data, 9'h0FB);
        // R4 pulse with ack on same bit
        step(9'h004, 1, 1, 9'h004, 1, "R4 collide");
        chk(rd_data == 9'h004, "R4 set wins", rd_data, 9'h004);
        step('0, 1, 1, 9'h1FF, 1, "R3 ack all");
        chk(rd_data == '0, "R3 all cleared", rd_data, '0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] p = ($urandom_range(0, 3) == 0) ? N'($urandom) & N'($urandom) : '0;
            int k = $urandom_range(0, 9);
            logic we = (k < 5);
            logic s = (k != 0);
            logic [N-1:0] d = N'($urandom);
            step(p, we, s, d, 1'($urandom), "random");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule